// File: doc/BRIEF.md
# Cache Tag Memory with Comparator

This block is a tag store with its own equality comparator, written as a synchronous model. It holds 4096 tags of 4 bits each. A 12-bit address picks one entry. A shared 4-bit tag bus carries a tag into the block for both writes and compares. Three active-low controls choose one of four operations:

- compare the presented tag against the stored one (the default when no control is asserted),
- store the presented tag,
- return the stored tag,
- wipe the whole array in a single cycle.

The `match` output is registered and is meant to be combined with other instances. ANDing the `match` outputs of several side-by-side instances that share an address gives a tag wider than 4 bits. A cache controller presents an address and a tag, then reads `match` one clock later. It ignores `match` whenever `match_valid` is low, which happens around a clear. Returned tags come out on a separate `tag_out` port. The `rd_valid` output qualifies them.

Top module: `tag_cmp_store`

## Requirements
- R1: While `rst_n` is low at a clock edge, every entry becomes zero, and after that edge `match`, `match_valid`, `rd_valid` and `tag_out` are all 0.
- R2: With `we_n`, `oe_n` and `clr_n` all high at an edge, `match` after that edge is 1 when all 4 bits of `tag_in` equal the entry at `addr`. It is 0 when any single bit differs.
- R3: With `clr_n` high and `we_n` low at an edge, `tag_in` is stored at `addr`. The state of `oe_n` has no effect: `rd_valid` is 0 after that edge.
- R4: With `clr_n` and `we_n` high and `oe_n` low at an edge, `tag_out` after that edge holds the entry at `addr` and `rd_valid` is 1. In every other mode `rd_valid` and `tag_out` are 0.
- R5: After a write edge and after a read edge, `match` is 1, because the bus tag equals the stored tag.
- R6: `clr_n` low at an edge makes every entry read as zero from the next edge on, regardless of `we_n` and `oe_n`. A write requested in the same cycle is not stored.
- R7: `match_valid` is 0 after an edge where `clr_n` was low, and also after the following edge. After every other edge following reset it is 1.
- R8: Entries at the lowest address (0) and the highest address (4095) are stored independently of each other and of other entries.
- R9: An entry never written since the last reset or clear reads as 0 and matches tag 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 12 | Entry select |
| tag_in | input | 4 | Tag presented for compare or write |
| we_n | input | 1 | Active-low write request |
| oe_n | input | 1 | Active-low read request |
| clr_n | input | 1 | Active-low whole-array clear; overrides the other controls |
| tag_out | output | 4 | Stored tag returned by a read |
| rd_valid | output | 1 | High when `tag_out` holds read data |
| match | output | 1 | Registered result of the tag compare |
| match_valid | output | 1 | High when `match` may be used |

## Verification
Compares are driven in three ways:

- Tags that differ from the stored one in exactly one bit, taking each bit position in turn. This catches a comparator that ignores a bit position.
- The exact stored value.
- The value zero against untouched entries. This separates a missing clear or missing reset from a working one.

Writes are mixed with reads on the same and on neighbouring addresses, including the two ends of the address range. This tells a store that aliases entries apart from one that keeps them separate. Clears are issued together with write and read requests, which shows whether the clear really wins. Compares follow right after a clear, which shows the two-cycle `match_valid` blanking.

// File: rtl/tagstore_pkg.sv
// Package: shared types for the cache tag store.
// Assumes: nothing beyond standard SystemVerilog.
package tagstore_pkg;

    // Operation chosen for one clock cycle by the three active-low controls.
    typedef enum logic [1:0] {
        MODE_MATCH = 2'd0,
        MODE_WRITE = 2'd1,
        MODE_READ  = 2'd2,
        MODE_CLEAR = 2'd3
    } tag_mode_e;

endpackage

// File: rtl/tagstore_decode.sv
// Module: tagstore_decode
// Turns the three active-low controls into one operation code.
// Priority order: clear, then write, then read; compare when none is low.
// Assumes: controls are already synchronous to the clock.
module tagstore_decode
    import tagstore_pkg::*;
(
    input  logic      we_n,
    input  logic      oe_n,
    input  logic      clr_n,
    output tag_mode_e mode
);

    // Purpose: fixed-priority decode of the control pins.
    always_comb begin
        if (!clr_n)     mode = MODE_CLEAR;
        else if (!we_n) mode = MODE_WRITE;
        else if (!oe_n) mode = MODE_READ;
        else            mode = MODE_MATCH;
    end

endmodule

// File: rtl/tagstore_array.sv
// Module: tagstore_array
// Tag storage with one valid flag per entry.
// A whole-array clear drops every flag in one cycle. An entry whose flag is
// low reads as zero, so the tag bits never need rewriting on a clear.
// Assumes: clr_all and wr_en are never both high (the decoder guarantees
// this). The read port is combinational and shows contents before the edge.
module tagstore_array #(
    parameter int ADDR_W = 12,
    parameter int TAG_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_all,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [TAG_W-1:0]  wdata,
    output logic [TAG_W-1:0]  rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [TAG_W-1:0] tag_mem [DEPTH];
    logic [DEPTH-1:0] entry_vld;

    // Purpose: tag bits, written only on a write; they need no reset.
    always_ff @(posedge clk) begin
        if (wr_en) tag_mem[addr] <= wdata;
    end

    // Purpose: valid flags, cleared by reset or clear, set by a write.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) entry_vld <= '0;
        else if (wr_en)        entry_vld[addr] <= 1'b1;
    end

    // Purpose: read port that masks invalid entries to zero.
    always_comb begin
        rdata = entry_vld[addr] ? tag_mem[addr] : '0;
    end

    // R6: after a clear, no entry remains valid.
    a_r6_clear_drops_all: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (entry_vld == '0));

    // R3: a write leaves the target entry valid.
    a_r3_write_marks_valid: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> entry_vld[$past(addr)]);

endmodule

// File: rtl/tagstore_compare.sv
// Module: tagstore_compare
// Bitwise equality of two tags, reduced to one flag.
// Assumes: purely combinational; the caller registers the result.
module tagstore_compare #(
    parameter int TAG_W = 4
) (
    input  logic [TAG_W-1:0] lhs,
    input  logic [TAG_W-1:0] rhs,
    output logic             equal
);

    logic [TAG_W-1:0] bit_same;

    // One equality cell per tag bit.
    for (genvar i = 0; i < TAG_W; i++) begin : g_bit
        assign bit_same[i] = ~(lhs[i] ^ rhs[i]);
    end

    // Purpose: all bits must agree.
    always_comb begin
        equal = &bit_same;
    end

endmodule

// File: rtl/tag_cmp_store.sv
// Module: tag_cmp_store
// Cache tag memory with a built-in comparator.
// Inputs are sampled on the rising edge. match, match_valid, tag_out and
// rd_valid are registered, so they are valid one cycle after the inputs.
// During a read the bus tag is the stored tag; during a write the stored tag
// becomes the bus tag. match is therefore high after either.
// Assumes: synchronous active-low reset held for at least one edge.
module tag_cmp_store
    import tagstore_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int TAG_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [TAG_W-1:0]  tag_in,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              clr_n,
    output logic [TAG_W-1:0]  tag_out,
    output logic              rd_valid,
    output logic              match,
    output logic              match_valid
);

    tag_mode_e        mode;
    logic [TAG_W-1:0] stored_tag;
    logic [TAG_W-1:0] bus_tag;
    logic [TAG_W-1:0] held_tag;
    logic             tags_equal;
    logic             clr_seen;

    tagstore_decode u_decode (
        .we_n  (we_n),
        .oe_n  (oe_n),
        .clr_n (clr_n),
        .mode  (mode)
    );

    tagstore_array #(
        .ADDR_W (ADDR_W),
        .TAG_W  (TAG_W)
    ) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_all (mode == MODE_CLEAR),
        .wr_en   (mode == MODE_WRITE),
        .addr    (addr),
        .wdata   (tag_in),
        .rdata   (stored_tag)
    );

    // Purpose: pick what sits on the bus and what the entry holds this cycle.
    always_comb begin
        bus_tag  = (mode == MODE_READ)  ? stored_tag : tag_in;
        held_tag = (mode == MODE_WRITE) ? tag_in     : stored_tag;
    end

    tagstore_compare #(
        .TAG_W (TAG_W)
    ) u_compare (
        .lhs   (bus_tag),
        .rhs   (held_tag),
        .equal (tags_equal)
    );

    // Purpose: register the compare result; held low during a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                  match <= 1'b0;
        else if (mode == MODE_CLEAR) match <= 1'b0;
        else                         match <= tags_equal;
    end

    // Purpose: blank match_valid for the clear cycle and the one after it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_seen    <= 1'b0;
            match_valid <= 1'b0;
        end else begin
            clr_seen    <= (mode == MODE_CLEAR);
            match_valid <= (mode != MODE_CLEAR) && !clr_seen;
        end
    end

    // Purpose: register read data and its qualifier.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_out  <= '0;
            rd_valid <= 1'b0;
        end else if (mode == MODE_READ) begin
            tag_out  <= stored_tag;
            rd_valid <= 1'b1;
        end else begin
            tag_out  <= '0;
            rd_valid <= 1'b0;
        end
    end

    // R5: match is high after a write.
    a_r5_match_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && !we_n) |=> match);

    // R5: match is high after a read.
    a_r5_match_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && we_n && !oe_n) |=> match);

    // R7: match_valid is low after the clear edge.
    a_r7_blank_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> !match_valid);

    // R7: match_valid is still low one edge later.
    a_r7_blank_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> ##1 !match_valid);

    // R4: a read request yields rd_valid.
    a_r4_read_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && we_n && !oe_n) |=> rd_valid);

    // R3: a write yields no read data, whatever oe_n is.
    a_r3_write_ignores_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && !we_n) |=> !rd_valid);

    // R4: no read data without a read request.
    a_r4_no_stray_read: assert property (@(posedge clk) disable iff (!rst_n)
        !(clr_n && we_n && !oe_n) |=> (!rd_valid && tag_out == '0));

endmodule

// File: tb/sim_tag_cmp_store.sv
// Bench: behavioural reference model of the tag store, compared every clock.
module sim_tag_cmp_store;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 12;
    localparam int TW = 4;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [TW-1:0] tag_in = '0;
    logic          we_n = 1'b1;
    logic          oe_n = 1'b1;
    logic          clr_n = 1'b1;
    logic [TW-1:0] tag_out;
    logic          rd_valid;
    logic          match;
    logic          match_valid;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [TW-1:0] model_mem [DEPTH];
    bit            model_prev_clr = 0;

    tag_cmp_store #(.ADDR_W(AW), .TAG_W(TW)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .tag_in(tag_in),
        .we_n(we_n), .oe_n(oe_n), .clr_n(clr_n),
        .tag_out(tag_out), .rd_valid(rd_valid),
        .match(match), .match_valid(match_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input string what, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, got, exp, $time);
        end
    endtask

    // One clock of stimulus; expectations come from the model before the edge.
    task automatic cyc(input string req, input int a, input int d,
                       input bit we, input bit oe, input bit clr);
        bit exp_m, exp_mv, exp_rv;
        int exp_t;
        addr = a[AW-1:0]; tag_in = d[TW-1:0];
        we_n = we; oe_n = oe; clr_n = clr;
        exp_mv = clr && !model_prev_clr;
        exp_m = 0; exp_rv = 0; exp_t = 0;
        if (!clr) begin
            for (int i = 0; i < DEPTH; i++) model_mem[i] = '0;
        end else if (!we) begin
            exp_m = 1;
            model_mem[a] = d[TW-1:0];
        end else if (!oe) begin
            exp_m = 1; exp_rv = 1; exp_t = model_mem[a];
        end else begin
            exp_m = (model_mem[a] == d[TW-1:0]);
        end
        model_prev_clr = !clr;
        @(posedge clk);
        #1;
        check(req, "match_valid", match_valid, exp_mv);
        if (clr) check(req, "match", match, exp_m);
        check(req, "rd_valid", rd_valid, exp_rv);
        check(req, "tag_out", tag_out, exp_t);
    endtask

    task automatic cmp_only(input string req, input int a, input int d);
        cyc(req, a, d, 1, 1, 1);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) model_mem[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R1", "match", match, 0);
        check("R1", "match_valid", match_valid, 0);
        check("R1", "rd_valid", rd_valid, 0);
        check("R1", "tag_out", tag_out, 0);
        rst_n = 1'b1;

        // R9 / R1: untouched entries read and match as zero.
        cyc("R9", 100, 0, 1, 0, 1);
        cmp_only("R9", 100, 0);
        cmp_only("R9", 101, 5);

        // R3: write with oe_n high and with oe_n low.
        cyc("R3", 100, 4'hA, 0, 1, 1);
        cyc("R3", 200, 4'h5, 0, 0, 1);
        cyc("R4", 100, 0, 1, 0, 1);
        cyc("R4", 200, 0, 1, 0, 1);

        // R2: hit, then each single-bit miss.
        cmp_only("R2", 100, 4'hA);
        for (int b = 0; b < TW; b++) cmp_only("R2", 100, 4'hA ^ (1 << b));
        for (int b = 0; b < TW; b++) cmp_only("R2", 200, 4'h5 ^ (1 << b));
        cmp_only("R2", 200, 4'h5);

        // R8: both ends of the address range.
        cyc("R8", 0, 4'h3, 0, 1, 1);
        cyc("R8", DEPTH-1, 4'hC, 0, 1, 1);
        cyc("R8", 0, 0, 1, 0, 1);
        cyc("R8", DEPTH-1, 0, 1, 0, 1);
        cmp_only("R8", 1, 0);
        cmp_only("R8", DEPTH-2, 0);

        // R5: overwrite then compare against new and old values.
        cyc("R5", 100, 4'hF, 0, 1, 1);
        cmp_only("R5", 100, 4'hF);
        cmp_only("R5", 100, 4'hA);

        // R6/R7: clear with write requested; write is lost.
        cyc("R6", 300, 4'h7, 0, 0, 0);
        cmp_only("R7", 100, 0);
        cmp_only("R6", 100, 0);
        cyc("R6", 300, 0, 1, 0, 1);
        cyc("R6", DEPTH-1, 0, 1, 0, 1);
        cmp_only("R6", 200, 4'h5);

        // R7: back-to-back clears, clear with read requested.
        cyc("R3", 50, 4'h9, 0, 1, 1);
        cyc("R7", 0, 0, 1, 1, 0);
        cyc("R7", 0, 0, 1, 0, 0);
        cyc("R7", 50, 4'h9, 1, 0, 1);
        cmp_only("R7", 50, 0);

        // Mixed pattern across a small address window.
        for (int k = 0; k < 16; k++) cyc("R3", 1000 + k, k, 0, k % 2, 1);
        for (int k = 0; k < 16; k++) cmp_only("R2", 1000 + k, (k * 7) % 16);
        for (int k = 0; k < 16; k++) cyc("R4", 1000 + k, 0, 1, 0, 1);

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule